// File: doc/BRIEF.md
# AGC Truncation Error Estimator

This block measures how much of a complex baseband stream is thrown away when each I and Q sample is cut down to a shorter output word, and turns that loss into an error term for a gain control loop. Each accepted sample is reduced to a programmable number of kept bits. The discarded low part of I and of Q forms a residue. The squared magnitude of that residue pair is summed over a window of samples, averaged, and passed through an integer square root. The result is an rms estimate of the truncation loss.

A programmable clipping target is subtracted from the rms value, and the signed difference is presented with a one-cycle strobe once per window. A downstream loop filter, which is not part of this block, drives that difference toward zero. In this way the gain settles where the loss to truncation stays at a chosen level, rather than where the signal power meets a fixed target.

Top module: `trunc_err_est`

## Requirements
- R1: `wl_sel` picks how many top bits are kept: code 0→4, 1→5, 2→6, 3→7, 4→8, 5→10, 6→12, 7→16. The residue of a sample is its low (16 − kept) bits read as an unsigned number. This equals the sample minus its value truncated toward minus infinity, so code 7 always gives a residue of zero.
- R2: The I and Q residues are formed independently, each from its own input only.
- R3: For each accepted sample the block forms eI² + eQ², where eI and eQ are the two residues.
- R4: A window holds 2^k samples with `in_valid` high, where k is `avg_log2` and any value above 12 acts as 12. The window mean is floor(sum / 2^k). Cycles with `in_valid` low do not change the sum or the count, whatever the data inputs carry.
- R5: `out_rms` equals floor(sqrt(mean)) of the window just closed.
- R6: `out_err` equals `out_rms` − `clip_level` as an 18-bit two's-complement number. It is negative exactly when `out_rms` is below `clip_level`.
- R7: `out_valid` is a single-cycle pulse, high for one clock per window. It goes high right after the 19th rising edge that follows the edge sampling the window's last sample.
- R8: While `rst` is high, and after it falls, no result is reported until a new window completes. Any partly filled window is discarded.
- R9: Consecutive windows are independent. The sum restarts at zero after each result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Sample strobe for `in_i` and `in_q` |
| in_i | input | 16 | In-phase sample, signed |
| in_q | input | 16 | Quadrature sample, signed |
| wl_sel | input | 3 | Output word-length code |
| avg_log2 | input | 4 | log2 of the window length |
| clip_level | input | 17 | Desired rms truncation level, unsigned |
| out_valid | output | 1 | Result strobe, one per window |
| out_rms | output | 17 | rms of the truncation residue |
| out_err | output | 18 | Signed error, rms minus target |

## Verification
The properties assume that window ends come no closer than 18 cycles apart. The square-root engine is bit-serial, and a new mean arriving while it is still running would be lost. One property states this as an input constraint. The bench meets it by spacing samples 25 to 30 cycles apart whenever windows are short, and by using one long window for the only burst of back-to-back samples. The residue-bound property also assumes that `wl_sel` is held steady while a sample is in flight. The stimulus changes it only between windows.

// File: rtl/tee_pkg.sv
package tee_pkg;

    localparam int IN_W     = 16;
    localparam int LANES    = 2;
    localparam int WL_W     = 3;
    localparam int AVG_W    = 4;
    localparam int MAX_LOG2 = 12;
    localparam int CNT_W    = MAX_LOG2;
    localparam int RSH_W    = $clog2(IN_W + 1);
    localparam int MAG_W    = 2 * IN_W + 1;
    localparam int ACC_W    = MAG_W + MAX_LOG2;
    localparam int ROOT_W   = (MAG_W + 1) / 2;
    localparam int RAD_W    = 2 * ROOT_W;
    localparam int CAND_W   = ROOT_W + 3;
    localparam int ITER_W   = $clog2(ROOT_W + 1);
    localparam int ERR_W    = ROOT_W + 1;

    typedef struct packed {
        logic [IN_W-1:0] i;
        logic [IN_W-1:0] q;
    } iq_t;

    typedef struct packed {
        logic             valid;
        logic [MAG_W-1:0] mag;
    } mag_beat_t;

    typedef struct packed {
        logic             valid;
        logic [MAG_W-1:0] mean;
    } upd_beat_t;

    typedef enum logic {
        SQ_IDLE = 1'b0,
        SQ_RUN  = 1'b1
    } sq_state_t;

    // Number of low bits dropped for each word-length code.
    function automatic logic [RSH_W-1:0] res_bits(input logic [WL_W-1:0] code);
        case (code)
            3'd0:    return RSH_W'(IN_W - 4);
            3'd1:    return RSH_W'(IN_W - 5);
            3'd2:    return RSH_W'(IN_W - 6);
            3'd3:    return RSH_W'(IN_W - 7);
            3'd4:    return RSH_W'(IN_W - 8);
            3'd5:    return RSH_W'(IN_W - 10);
            3'd6:    return RSH_W'(IN_W - 12);
            default: return RSH_W'(0);
        endcase
    endfunction

    // Largest eI^2 + eQ^2 that a word-length code can produce.
    function automatic logic [MAG_W-1:0] mag_limit(input logic [WL_W-1:0] code);
        logic [MAG_W-1:0] r;
        r = (MAG_W'(1) << res_bits(code)) - MAG_W'(1);
        return (r * r) << 1;
    endfunction

endpackage

// File: rtl/tee_residue.sv
module tee_residue
    import tee_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            in_valid,
    input  iq_t             in_iq,
    input  logic [WL_W-1:0] wl_sel,
    output mag_beat_t       mag_o
);

    logic [RSH_W-1:0] drop_bits;
    logic [IN_W-1:0]  keep_mask;
    logic [IN_W-1:0]  lane_in [LANES];
    logic [2*IN_W-1:0] lane_sq [LANES];
    logic [MAG_W-1:0] mag_sum;

    assign drop_bits  = res_bits(wl_sel);
    assign keep_mask  = ~({IN_W{1'b1}} << drop_bits);
    assign lane_in[0] = in_iq.i;
    assign lane_in[1] = in_iq.q;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [IN_W-1:0] resid;
        assign resid      = lane_in[g] & keep_mask;
        assign lane_sq[g] = resid * resid;
    end

    assign mag_sum = {1'b0, lane_sq[0]} + {1'b0, lane_sq[1]};

    always_ff @(posedge clk) begin
        if (rst) begin
            mag_o <= '0;
        end else begin
            mag_o.valid <= in_valid;
            if (in_valid) begin
                mag_o.mag <= mag_sum;
            end
        end
    end

endmodule

// File: rtl/tee_accum.sv
module tee_accum
    import tee_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  mag_beat_t        mag_i,
    input  logic [AVG_W-1:0] avg_log2,
    output upd_beat_t        upd_o
);

    logic [AVG_W-1:0] k_eff;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] last_idx;
    logic [ACC_W-1:0] acc;
    logic [ACC_W-1:0] acc_sum;
    logic [MAG_W-1:0] shifted [MAX_LOG2+1];
    logic [MAG_W-1:0] mean_sel;

    assign k_eff    = (avg_log2 > AVG_W'(MAX_LOG2)) ? AVG_W'(MAX_LOG2) : avg_log2;
    assign last_idx = ~({CNT_W{1'b1}} << k_eff);
    assign acc_sum  = acc + ACC_W'(mag_i.mag);

    for (genvar g = 0; g <= MAX_LOG2; g++) begin : g_shift
        assign shifted[g] = acc_sum[g +: MAG_W];
    end

    always_comb begin
        mean_sel = shifted[0];
        for (int s = 1; s <= MAX_LOG2; s++) begin
            if (k_eff == AVG_W'(s)) begin
                mean_sel = shifted[s];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt   <= '0;
            acc   <= '0;
            upd_o <= '0;
        end else begin
            upd_o.valid <= 1'b0;
            if (mag_i.valid) begin
                if (cnt == last_idx) begin
                    upd_o.valid <= 1'b1;
                    upd_o.mean  <= mean_sel;
                    acc         <= '0;
                    cnt         <= '0;
                end else begin
                    acc <= acc_sum;
                    cnt <= cnt + CNT_W'(1);
                end
            end
        end
    end

endmodule

// File: rtl/tee_isqrt.sv
module tee_isqrt
    import tee_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [MAG_W-1:0]  radicand,
    output logic              busy,
    output logic              done,
    output logic [ROOT_W-1:0] result
);

    sq_state_t         state;
    logic [RAD_W-1:0]  rad_sh;
    logic [CAND_W-1:0] rem;
    logic [ROOT_W-1:0] root;
    logic [ITER_W-1:0] iter;

    logic [CAND_W-1:0] cand;
    logic [CAND_W-1:0] trial;
    logic              rem_ovf;
    logic              take;
    logic [CAND_W-1:0] rem_nx;
    logic [ROOT_W-1:0] root_nx;

    assign cand    = {rem[CAND_W-3:0], rad_sh[RAD_W-1 -: 2]};
    assign trial   = {1'b0, root, 2'b01};
    assign rem_ovf = |rem[CAND_W-1 -: 2];
    assign take    = rem_ovf || (cand >= trial);
    assign rem_nx  = take ? (cand - trial) : cand;
    assign root_nx = {root[ROOT_W-2:0], take};
    assign busy    = (state == SQ_RUN);

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= SQ_IDLE;
            rad_sh <= '0;
            rem    <= '0;
            root   <= '0;
            iter   <= '0;
            done   <= 1'b0;
            result <= '0;
        end else begin
            done <= 1'b0;
            case (state)
                SQ_IDLE: begin
                    if (start) begin
                        rad_sh <= RAD_W'(radicand);
                        rem    <= '0;
                        root   <= '0;
                        iter   <= ITER_W'(ROOT_W);
                        state  <= SQ_RUN;
                    end
                end
                default: begin
                    rad_sh <= {rad_sh[RAD_W-3:0], 2'b00};
                    rem    <= rem_nx;
                    root   <= root_nx;
                    iter   <= iter - ITER_W'(1);
                    if (iter == ITER_W'(1)) begin
                        result <= root_nx;
                        done   <= 1'b1;
                        state  <= SQ_IDLE;
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/trunc_err_est.sv
module trunc_err_est
    import tee_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    in_valid,
    input  logic [IN_W-1:0]         in_i,
    input  logic [IN_W-1:0]         in_q,
    input  logic [WL_W-1:0]         wl_sel,
    input  logic [AVG_W-1:0]        avg_log2,
    input  logic [ROOT_W-1:0]       clip_level,
    output logic                    out_valid,
    output logic [ROOT_W-1:0]       out_rms,
    output logic signed [ERR_W-1:0] out_err
);

    iq_t       in_iq;
    mag_beat_t mag_b;
    upd_beat_t upd_b;
    logic      sq_busy;

    assign in_iq.i = in_i;
    assign in_iq.q = in_q;

    tee_residue u_residue (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_iq    (in_iq),
        .wl_sel   (wl_sel),
        .mag_o    (mag_b)
    );

    tee_accum u_accum (
        .clk      (clk),
        .rst      (rst),
        .mag_i    (mag_b),
        .avg_log2 (avg_log2),
        .upd_o    (upd_b)
    );

    tee_isqrt u_isqrt (
        .clk      (clk),
        .rst      (rst),
        .start    (upd_b.valid),
        .radicand (upd_b.mean),
        .busy     (sq_busy),
        .done     (out_valid),
        .result   (out_rms)
    );

    assign out_err = $signed({1'b0, out_rms}) - $signed({1'b0, clip_level});

endmodule

// File: rtl/tee_checker.sv
module tee_checker
    import tee_pkg::*;
(
    input logic                    clk,
    input logic                    rst,
    input logic [WL_W-1:0]         wl_sel,
    input logic                    mag_valid,
    input logic [MAG_W-1:0]        mag,
    input logic                    upd_valid,
    input logic [MAG_W-1:0]        upd_mean,
    input logic                    sq_busy,
    input logic [ROOT_W-1:0]       clip_level,
    input logic                    out_valid,
    input logic [ROOT_W-1:0]       out_rms,
    input logic signed [ERR_W-1:0] out_err
);

    localparam int SQ_W = 2 * ROOT_W + 2;

    logic [SQ_W-1:0] rms_sq;
    logic [SQ_W-1:0] rms_up_sq;

    assign rms_sq    = SQ_W'(out_rms) * SQ_W'(out_rms);
    assign rms_up_sq = (SQ_W'(out_rms) + SQ_W'(1)) * (SQ_W'(out_rms) + SQ_W'(1));

    // R1 and R3: the squared residue never exceeds what the kept width allows
    p_res_bound_r3: assert property (@(posedge clk) disable iff (rst)
        mag_valid |-> (mag <= mag_limit($past(wl_sel))));

    // R5: reported rms is the floor of the square root of the window mean
    p_sqrt_floor_r5: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> ((rms_sq <= SQ_W'(upd_mean)) && (rms_up_sq > SQ_W'(upd_mean))));

    // R6: sign of the error follows the comparison of rms and target
    p_err_sign_r6: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_err[ERR_W-1] == (out_rms < clip_level)));

    // R7: result strobe lasts a single cycle
    p_strobe_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> !out_valid);

    // R7: input constraint, a new window mean never meets a running root engine
    p_sqrt_free_r7: assert property (@(posedge clk) disable iff (rst)
        upd_valid |-> !sq_busy);

    // R8: nothing is reported in the cycle reset is released
    p_quiet_after_reset_r8: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> !out_valid);

endmodule

bind trunc_err_est tee_checker chk_i (
    .clk        (clk),
    .rst        (rst),
    .wl_sel     (wl_sel),
    .mag_valid  (mag_b.valid),
    .mag        (mag_b.mag),
    .upd_valid  (upd_b.valid),
    .upd_mean   (upd_b.mean),
    .sq_busy    (sq_busy),
    .clip_level (clip_level),
    .out_valid  (out_valid),
    .out_rms    (out_rms),
    .out_err    (out_err)
);

// File: tb/trunc_err_est_tb.sv
module trunc_err_est_tb_top;

    localparam int LAT = 19;

    typedef struct packed {
        logic [2:0]         wl;
        logic [15:0]        i;
        logic [15:0]        q;
        logic [16:0]        lvl;
        logic [16:0]        rms;
        logic signed [17:0] err;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{3'd7, 16'h1234, 16'hFFFB, 17'd0,    17'd0,    18'sd0},
        '{3'd0, 16'h0003, 16'h0004, 17'd2,    17'd5,    18'sd3},
        '{3'd4, 16'hFF0C, 16'h0005, 17'd20,   17'd13,   -18'sd7},
        '{3'd5, 16'h7FFF, 16'h8000, 17'd63,   17'd63,   18'sd0},
        '{3'd6, 16'h000F, 16'h000F, 17'd0,    17'd21,   18'sd21},
        '{3'd1, 16'h07FF, 16'h0000, 17'd5000, 17'd2047, -18'sd2953},
        '{3'd0, 16'h0FFF, 16'h0FFF, 17'd8191, 17'd5791, -18'sd2400},
        '{3'd2, 16'hABCD, 16'h1400, 17'd973,  17'd973,  18'sd0},
        '{3'd3, 16'h0002, 16'hFFFF, 17'd600,  17'd511,  -18'sd89}
    };

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               in_valid = 1'b0;
    logic [15:0]        in_i = '0;
    logic [15:0]        in_q = '0;
    logic [2:0]         wl_sel = '0;
    logic [3:0]         avg_log2 = '0;
    logic [16:0]        clip_level = '0;
    logic               out_valid;
    logic [16:0]        out_rms;
    logic signed [17:0] out_err;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    int n_out = 0;
    int got_cyc = 0;
    int last_e  = 0;
    logic [16:0]        got_rms = '0;
    logic signed [17:0] got_err = '0;

    always #5 clk = ~clk;

    trunc_err_est dut_i (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .in_i       (in_i),
        .in_q       (in_q),
        .wl_sel     (wl_sel),
        .avg_log2   (avg_log2),
        .clip_level (clip_level),
        .out_valid  (out_valid),
        .out_rms    (out_rms),
        .out_err    (out_err)
    );

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (!rst && out_valid) begin
            n_out   = n_out + 1;
            got_rms = out_rms;
            got_err = out_err;
            got_cyc = cyc;
        end
    end

    task automatic check(input string what, input longint act, input longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    task automatic feed(input logic [15:0] i, input logic [15:0] q, input int gap);
        @(negedge clk);
        last_e   = cyc + 1;
        in_valid = 1'b1;
        in_i     = i;
        in_q     = q;
        @(negedge clk);
        in_valid = 1'b0;
        in_i     = 16'hDEAD;
        in_q     = 16'hBEEF;
        repeat (gap) @(negedge clk);
    endtask

    task automatic do_reset(input int n);
        @(negedge clk);
        rst = 1'b1;
        repeat (n) @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 150000);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int n0;
        // R8: quiet during reset
        repeat (3) @(negedge clk);
        check("R8 out_valid in reset", out_valid, 0);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        check("R8 out_valid after reset", out_valid, 0);

        // Table: one-sample windows, R1 R2 R3 R5 R6 R7
        avg_log2 = 4'd0;
        for (int v = 0; v < NV; v++) begin
            wl_sel     = VECS[v].wl;
            clip_level = VECS[v].lvl;
            n0 = n_out;
            feed(VECS[v].i, VECS[v].q, 30);
            check($sformatf("R7 result count vec %0d", v), n_out - n0, 1);
            check($sformatf("R7 latency vec %0d", v), got_cyc - last_e, LAT);
            check($sformatf("R1 R2 R3 R5 rms vec %0d", v), got_rms, VECS[v].rms);
            check($sformatf("R6 err vec %0d", v), got_err, VECS[v].err);
        end

        // R4: window of four, invalid cycles carry garbage
        avg_log2 = 4'd2; wl_sel = 3'd0; clip_level = 17'd0;
        n0 = n_out;
        feed(16'h0003, 16'h0004, 25);
        feed(16'h0000, 16'h0000, 25);
        feed(16'h0006, 16'h0008, 25);
        check("R4 no early result", n_out - n0, 0);
        feed(16'h0001, 16'h0000, 25);
        check("R4 one result per window", n_out - n0, 1);
        check("R4 mean of four rms", got_rms, 5);

        // R4: code above 12 acts as 12 (4096 back-to-back samples)
        avg_log2 = 4'd15; clip_level = 17'd16;
        n0 = n_out;
        @(negedge clk);
        for (int s = 0; s < 4096; s++) begin
            last_e   = cyc + 1;
            in_valid = 1'b1;
            in_i     = 16'h0010;
            in_q     = 16'h0000;
            @(negedge clk);
        end
        in_valid = 1'b0;
        repeat (30) @(negedge clk);
        check("R4 clamp result count", n_out - n0, 1);
        check("R4 clamp latency", got_cyc - last_e, LAT);
        check("R4 clamp rms", got_rms, 16);
        check("R6 clamp err", got_err, 0);

        // R9: back-to-back windows stay independent
        avg_log2 = 4'd1; clip_level = 17'd0;
        n0 = n_out;
        feed(16'h0FFF, 16'h0FFF, 25);
        feed(16'h0FFF, 16'h0FFF, 25);
        check("R9 first window rms", got_rms, 5791);
        feed(16'h0003, 16'h0004, 25);
        feed(16'h0003, 16'h0004, 25);
        check("R9 second window rms", got_rms, 5);
        check("R9 two results", n_out - n0, 2);

        // R8: reset in mid-window drops the partial sum
        feed(16'h0FFF, 16'h0FFF, 5);
        do_reset(2);
        n0 = n_out;
        feed(16'h0003, 16'h0004, 25);
        check("R8 no result from partial window", n_out - n0, 0);
        feed(16'h0000, 16'h0000, 25);
        check("R8 result count after reset", n_out - n0, 1);
        check("R8 rms after reset", got_rms, 3);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule